// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Logic for a Clock/Calendar

This block sits beside the counter chain of a low-power real-time clock. It watches the running time-of-day and calendar counters, compares them with a set of programmed alarm bytes, runs a two-digit BCD timer, and produces one-cycle pulses that tell the control/status register to set its alarm flag or its timer flag. The flags themselves live outside the block and come back in as inputs. The block uses them, together with two interrupt enables, to drive an active-low interrupt output.

The alarm control byte selects how the clock alarm compares. A daily alarm checks only the time of day. A dated alarm also checks the date and the month. A weekday alarm checks the time of day and also needs the current weekday's bit to be set in a seven-day mask. The same byte turns on a timer alarm, which fires when the timer equals a programmed value. It also picks the tick that advances the timer: hundredths, seconds, minutes, hours or days. When the global alarm enable is off, no alarms or timer activity take place. In that state, in clock mode, the interrupt output becomes a 1 Hz square wave that can be used for calibration.

Top module: `alarm_timer_irq`

## Requirements
- R1: `timer_val` is a BCD value 00..99. Each selected tick adds one. From 0x99 it wraps to 0x00. When `tmr_load` is high, the next edge loads `tmr_load_val`, and the load takes priority over a tick.
- R2: `acr[2:0]` selects the tick that advances the timer. 1 selects `tick[0]` (hundredths), 2 selects `tick[1]` (seconds), 3 selects `tick[2]` (minutes), 4 selects `tick[3]` (hours) and 5 selects `tick[4]` (days). Values 0, 6 and 7 stop the timer. Ticks that are not selected are ignored. The timer only advances while `alarm_en` is 1.
- R3: `timer_set` is high for exactly the one cycle after the edge on which the timer wraps from 0x99 to 0x00.
- R4: Daily mode (`acr[5:4]`=01) compares the four time bytes bit for bit: hundredths in `cnt_time[7:0]`, then seconds, minutes and hours in the higher bytes. The date and weekday/month bytes are ignored.
- R5: Dated mode (`acr[5:4]`=11) also compares the date (`[5:0]` of the date byte) and the month (`[4:0]` of the weekday/month byte). The year bits `[7:6]` and the weekday bits `[7:5]` are ignored.
- R6: Weekday mode (`acr[5:4]`=10) needs a time match and needs bit w of `alm_wdmon` to be 1, where w = `cnt_wdmon[7:5]`. A weekday code of 7 never matches.
- R7: When `acr[6]`=1, a timer alarm condition exists while `timer_val` equals `alm_timer`.
- R8: `alarm_set` pulses for one cycle on the edge after a clock-alarm or timer-alarm condition first appears. A condition that persists does not pulse again. Mode 00, or `alarm_en`=0, gives no alarm condition.
- R9: With `alarm_en`=1, `int_n` is low one cycle after (`alarm_flag` and `acr[7]`) or (`timer_flag` and `acr[3]`) holds. Otherwise it is high.
- R10: With `alarm_en`=0 and `clk_mode`=1, `int_n` is low while the BCD hundredths value is 00..49 and high while it is 50..99, with a one-cycle delay. With `alarm_en`=0 and `clk_mode`=0 it is high.
- R11: After reset, `timer_val` is 0x00, `alarm_set` and `timer_set` are 0, and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode | input | 1 | 1 when the counter chain runs as a clock |
| alarm_en | input | 1 | Global alarm enable from the control/status byte |
| alarm_flag | input | 1 | Current alarm flag |
| timer_flag | input | 1 | Current timer flag |
| acr | input | 8 | Alarm control byte |
| cnt_time | input | 32 | Hours, minutes, seconds, hundredths counters (BCD, hundredths lowest) |
| cnt_date | input | 8 | Year [7:6], date [5:0] |
| cnt_wdmon | input | 8 | Weekday [7:5], month [4:0] |
| alm_time | input | 32 | Alarm time bytes, same layout as cnt_time |
| alm_date | input | 8 | Alarm date byte |
| alm_wdmon | input | 8 | Alarm month byte, or weekday mask in weekday mode |
| alm_timer | input | 8 | Timer alarm value |
| tick | input | 5 | Unit strobes: hundredths, seconds, minutes, hours, days |
| tmr_load | input | 1 | Load the timer |
| tmr_load_val | input | 8 | Value to load |
| alarm_set | output | 1 | Pulse that sets the alarm flag |
| timer_set | output | 1 | Pulse that sets the timer flag |
| timer_val | output | 8 | Timer value, BCD |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions check several properties on every cycle. A wrap pulse always comes with a zero timer and never lasts two cycles. The timer stays frozen while alarms are disabled and no load is made. No alarm pulse follows a cycle in which alarm_en was low. The interrupt line stays released while both flags are clear. The bench scenarios cover the rest: the ignored fields in each compare mode, the weekday mask, the single pulse for a match that persists, the choice of unit, the timer-alarm match and the calibration square wave. For these it compares against a behavioural model on every clock and also makes directed checks.

// File: rtl/atm_pkg.sv
package atm_pkg;

  typedef enum logic [1:0] {
    AM_NONE    = 2'b00,
    AM_DAILY   = 2'b01,
    AM_WEEKDAY = 2'b10,
    AM_DATED   = 2'b11
  } alm_mode_e;

  localparam int unsigned TMR_W     = 8;
  localparam int unsigned UNIT_W    = 3;
  localparam int unsigned DATE_W    = 6;
  localparam int unsigned MONTH_W   = 5;
  localparam int unsigned WDAY_LSB  = 5;
  localparam int unsigned WDAY_W    = 3;
  localparam logic [TMR_W-1:0] TMR_LAST = 8'h99;
  localparam logic [7:0] HALF_SEC_BCD   = 8'h50;

  function automatic logic [TMR_W-1:0] bcd_inc99(input logic [TMR_W-1:0] v);
    logic [TMR_W-1:0] r;
    if (v == TMR_LAST) begin
      r = '0;
    end else if (v[3:0] >= 4'd9) begin
      r = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

endpackage

// File: rtl/atm_rst_sync.sv
module atm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/atm_clk_cmp.sv
module atm_clk_cmp
  import atm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_TIME = 4
) (
  input  logic                       enable,
  input  alm_mode_e                  mode,
  input  logic [N_TIME*BYTE_W-1:0]   cnt_time,
  input  logic [N_TIME*BYTE_W-1:0]   alm_time,
  input  logic [BYTE_W-1:0]          cnt_date,
  input  logic [BYTE_W-1:0]          alm_date,
  input  logic [BYTE_W-1:0]          cnt_wdmon,
  input  logic [BYTE_W-1:0]          alm_wdmon,
  output logic                       match
);

  logic [N_TIME-1:0] fld_eq;
  logic              time_eq;
  logic              date_eq;
  logic              month_eq;
  logic [WDAY_W-1:0] wday;
  logic              wday_ok;

  for (genvar i = 0; i < N_TIME; i++) begin : g_fld
    assign fld_eq[i] = (cnt_time[i*BYTE_W +: BYTE_W] == alm_time[i*BYTE_W +: BYTE_W]);
  end

  assign time_eq  = &fld_eq;
  assign date_eq  = (cnt_date[DATE_W-1:0] == alm_date[DATE_W-1:0]);
  assign month_eq = (cnt_wdmon[MONTH_W-1:0] == alm_wdmon[MONTH_W-1:0]);
  assign wday     = cnt_wdmon[WDAY_LSB +: WDAY_W];
  assign wday_ok  = (wday != {WDAY_W{1'b1}}) && alm_wdmon[wday];

  always_comb begin
    match = 1'b0;
    if (enable) begin
      unique case (mode)
        AM_DAILY:   match = time_eq;
        AM_DATED:   match = time_eq && date_eq && month_eq;
        AM_WEEKDAY: match = time_eq && wday_ok;
        default:    match = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/atm_timer.sv
module atm_timer
  import atm_pkg::*;
#(
  parameter int unsigned N_UNITS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [UNIT_W-1:0]  unit_sel,
  input  logic [N_UNITS-1:0] tick,
  input  logic               load,
  input  logic [TMR_W-1:0]   load_val,
  output logic [TMR_W-1:0]   value,
  output logic               wrap
);

  logic [TMR_W-1:0] val_q, val_d;
  logic             wrap_q, wrap_d;
  logic             step;

  always_comb begin
    step = 1'b0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (unit_sel == UNIT_W'(u + 1)) begin
        step = tick[u];
      end
    end
    step = step && run;
  end

  always_comb begin
    val_d  = val_q;
    wrap_d = 1'b0;
    if (load) begin
      val_d = load_val;
    end else if (step) begin
      val_d  = bcd_inc99(val_q);
      wrap_d = (val_q == TMR_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      wrap_q <= wrap_d;
    end
  end

  assign value = val_q;
  assign wrap  = wrap_q;

endmodule

// File: rtl/atm_irq.sv
module atm_irq
  import atm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_en,
  input  logic              clk_mode,
  input  logic              alarm_flag,
  input  logic              timer_flag,
  input  logic              alarm_ie,
  input  logic              timer_ie,
  input  logic [BYTE_W-1:0] hund,
  output logic              int_n
);

  logic int_n_q, int_n_d;
  logic req;

  assign req = (alarm_flag && alarm_ie) || (timer_flag && timer_ie);

  always_comb begin
    if (alarm_en) begin
      int_n_d = !req;
    end else if (clk_mode) begin
      int_n_d = (hund >= BYTE_W'(HALF_SEC_BCD));
    end else begin
      int_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_n_q <= 1'b1;
    end else begin
      int_n_q <= int_n_d;
    end
  end

  assign int_n = int_n_q;

endmodule

// File: rtl/alarm_timer_irq.sv
module alarm_timer_irq
  import atm_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_TIME  = 4,
  parameter int unsigned N_UNITS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_mode,
  input  logic                     alarm_en,
  input  logic                     alarm_flag,
  input  logic                     timer_flag,
  input  logic [BYTE_W-1:0]        acr,
  input  logic [N_TIME*BYTE_W-1:0] cnt_time,
  input  logic [BYTE_W-1:0]        cnt_date,
  input  logic [BYTE_W-1:0]        cnt_wdmon,
  input  logic [N_TIME*BYTE_W-1:0] alm_time,
  input  logic [BYTE_W-1:0]        alm_date,
  input  logic [BYTE_W-1:0]        alm_wdmon,
  input  logic [BYTE_W-1:0]        alm_timer,
  input  logic [N_UNITS-1:0]       tick,
  input  logic                     tmr_load,
  input  logic [BYTE_W-1:0]        tmr_load_val,
  output logic                     alarm_set,
  output logic                     timer_set,
  output logic [BYTE_W-1:0]        timer_val,
  output logic                     int_n
);

  localparam int unsigned TIE_BIT  = 3;
  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned TAE_BIT  = 6;
  localparam int unsigned AIE_BIT  = 7;

  logic      rst_i_n;
  alm_mode_e mode;
  logic      clk_match;
  logic      tmr_match;
  logic      clk_match_q, tmr_match_q;
  logic      aset_q, aset_d;

  atm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i_n)
  );

  assign mode = alm_mode_e'(acr[MODE_LSB +: 2]);

  atm_clk_cmp #(.BYTE_W(BYTE_W), .N_TIME(N_TIME)) u_cmp (
    .enable    (alarm_en),
    .mode      (mode),
    .cnt_time  (cnt_time),
    .alm_time  (alm_time),
    .cnt_date  (cnt_date),
    .alm_date  (alm_date),
    .cnt_wdmon (cnt_wdmon),
    .alm_wdmon (alm_wdmon),
    .match     (clk_match)
  );

  atm_timer #(.N_UNITS(N_UNITS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (alarm_en),
    .unit_sel (acr[UNIT_W-1:0]),
    .tick     (tick),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .value    (timer_val),
    .wrap     (timer_set)
  );

  assign tmr_match = alarm_en && acr[TAE_BIT] && (timer_val == alm_timer);

  always_comb begin
    aset_d = (clk_match && !clk_match_q) || (tmr_match && !tmr_match_q);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      clk_match_q <= 1'b0;
      tmr_match_q <= 1'b0;
      aset_q      <= 1'b0;
    end else begin
      clk_match_q <= clk_match;
      tmr_match_q <= tmr_match;
      aset_q      <= aset_d;
    end
  end

  assign alarm_set = aset_q;

  atm_irq #(.BYTE_W(BYTE_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .alarm_en   (alarm_en),
    .clk_mode   (clk_mode),
    .alarm_flag (alarm_flag),
    .timer_flag (timer_flag),
    .alarm_ie   (acr[AIE_BIT]),
    .timer_ie   (acr[TIE_BIT]),
    .hund       (cnt_time[BYTE_W-1:0]),
    .int_n      (int_n)
  );

endmodule

// File: rtl/atm_chk.sv
module atm_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alarm_en,
  input logic              tmr_load,
  input logic              alarm_flag,
  input logic              timer_flag,
  input logic              alarm_set,
  input logic              timer_set,
  input logic [BYTE_W-1:0] timer_val,
  input logic              int_n
);

  AST_WRAP_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    timer_set |-> (timer_val == '0)); // R3

  AST_WRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_set |=> !timer_set); // R3

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_en && !tmr_load) |=> $stable(timer_val)); // R2

  AST_NO_ALARM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |=> !alarm_set); // R8

  AST_INT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && !alarm_flag && !timer_flag) |=> int_n); // R9

endmodule

bind alarm_timer_irq atm_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alarm_en   (alarm_en),
  .tmr_load   (tmr_load),
  .alarm_flag (alarm_flag),
  .timer_flag (timer_flag),
  .alarm_set  (alarm_set),
  .timer_set  (timer_set),
  .timer_val  (timer_val),
  .int_n      (int_n)
);

// File: tb/alarm_timer_irq_tb.sv
module alarm_timer_irq_tb;

  logic        clk;
  logic        rst_n;
  logic        clk_mode, alarm_en, alarm_flag, timer_flag;
  logic [7:0]  acr;
  logic [31:0] cnt_time, alm_time;
  logic [7:0]  cnt_date, cnt_wdmon, alm_date, alm_wdmon, alm_timer;
  logic [4:0]  tick;
  logic        tmr_load;
  logic [7:0]  tmr_load_val;
  logic        alarm_set, timer_set, int_n;
  logic [7:0]  timer_val;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  alarm_timer_irq u_dut (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .alarm_en(alarm_en),
    .alarm_flag(alarm_flag), .timer_flag(timer_flag), .acr(acr),
    .cnt_time(cnt_time), .cnt_date(cnt_date), .cnt_wdmon(cnt_wdmon),
    .alm_time(alm_time), .alm_date(alm_date), .alm_wdmon(alm_wdmon),
    .alm_timer(alm_timer), .tick(tick), .tmr_load(tmr_load),
    .tmr_load_val(tmr_load_val), .alarm_set(alarm_set), .timer_set(timer_set),
    .timer_val(timer_val), .int_n(int_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_timer;
  bit m_tset, m_aset, m_int, m_cm_prev, m_tm_prev;

  function automatic int bcd2int(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] int2bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic bit model_clock_match();
    bit t;
    int wd;
    if (!alarm_en || acr[5:4] == 2'b00) return 0;
    t = (cnt_time == alm_time);
    wd = int'(cnt_wdmon) / 32;
    case (acr[5:4])
      2'b01:   return t;
      2'b11:   return t && ((cnt_date % 64) == (alm_date % 64)) && ((cnt_wdmon % 32) == (alm_wdmon % 32));
      default: return t && (wd < 7) && (((int'(alm_wdmon) >> wd) % 2) == 1);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_timer <= 0; m_tset <= 0; m_aset <= 0; m_int <= 1; m_cm_prev <= 0; m_tm_prev <= 0;
    end else begin
      bit cm, tm, adv;
      int unit;
      cm = model_clock_match();
      tm = alarm_en && acr[6] && (int2bcd(m_timer) == alm_timer);
      m_aset <= (cm && !m_cm_prev) || (tm && !m_tm_prev);
      m_cm_prev <= cm;
      m_tm_prev <= tm;
      unit = int'(acr[2:0]);
      adv = alarm_en && unit >= 1 && unit <= 5 && tick[unit-1];
      if (tmr_load) begin
        m_timer <= bcd2int(tmr_load_val); m_tset <= 0;
      end else if (adv) begin
        m_timer <= (m_timer == 99) ? 0 : m_timer + 1;
        m_tset  <= (m_timer == 99);
      end else begin
        m_tset <= 0;
      end
      if (alarm_en) m_int <= !((alarm_flag && acr[7]) || (timer_flag && acr[3]));
      else if (clk_mode) m_int <= (bcd2int(cnt_time[7:0]) >= 50);
      else m_int <= 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(timer_val == int2bcd(m_timer), "R1 timer_val per-cycle", timer_val, int2bcd(m_timer));
      chk(timer_set == m_tset, "R3 timer_set per-cycle", timer_set, m_tset);
      chk(alarm_set == m_aset, "R8 alarm_set per-cycle", alarm_set, m_aset);
      chk(int_n == m_int, "R9 int_n per-cycle", int_n, m_int);
    end
  end

  task automatic adv(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; clk_mode = 0; alarm_en = 0; alarm_flag = 0; timer_flag = 0;
    acr = 8'h00; cnt_time = 32'h12345678; alm_time = 32'h0; cnt_date = 0;
    cnt_wdmon = 0; alm_date = 0; alm_wdmon = 0; alm_timer = 8'hFF; tick = 0;
    tmr_load = 0; tmr_load_val = 0;
    adv(3);
    look();
    chk(timer_val == 8'h00, "R11 reset timer_val", timer_val, 0);
    chk(!alarm_set && !timer_set, "R11 reset pulses", {alarm_set, timer_set}, 0);
    chk(int_n == 1'b1, "R11 reset int_n", int_n, 1);
    adv(1); rst_n = 1;
    adv(4);
    cmp_on = 1;

    // R1/R3: load and wrap with hundredths unit
    alarm_en = 1; acr = 8'h01; tmr_load = 1; tmr_load_val = 8'h97;
    adv(); tmr_load = 0;
    look(); chk(timer_val == 8'h97, "R1 load", timer_val, 8'h97);
    tick = 5'b00001; adv(2);
    look(); chk(timer_val == 8'h99, "R1 count to 99", timer_val, 8'h99);
    adv();
    look(); chk(timer_val == 8'h00 && timer_set, "R3 wrap pulse", {timer_set, timer_val}, 9'h100);
    tick = 0; adv();
    look(); chk(!timer_set, "R3 pulse one cycle", timer_set, 0);

    // R1: BCD digit carry 09 -> 10, load priority over tick
    tmr_load = 1; tmr_load_val = 8'h09; tick = 5'b00001; adv(); tmr_load = 0; adv();
    look(); chk(timer_val == 8'h10, "R1 BCD carry", timer_val, 8'h10);

    // R2: seconds unit ignores hundredths tick
    acr = 8'h02; tick = 5'b11101; adv(2);
    look(); chk(timer_val == 8'h10, "R2 unselected ticks ignored", timer_val, 8'h10);
    tick = 5'b00010; adv();
    look(); chk(timer_val == 8'h11, "R2 seconds tick", timer_val, 8'h11);
    acr = 8'h05; tick = 5'b10000; adv();
    look(); chk(timer_val == 8'h12, "R2 days tick", timer_val, 8'h12);
    acr = 8'h07; tick = 5'b11111; adv(2);
    look(); chk(timer_val == 8'h12, "R2 code 7 stops", timer_val, 8'h12);
    acr = 8'h01; alarm_en = 0; adv(2);
    look(); chk(timer_val == 8'h12, "R2 frozen without alarm_en", timer_val, 8'h12);
    tick = 0; alarm_en = 1;

    // R4: daily alarm ignores date bytes
    alm_time = 32'h08301500; cnt_date = 8'h05; alm_date = 8'h21;
    cnt_wdmon = 8'h03; alm_wdmon = 8'h0C;
    acr = 8'h10; cnt_time = 32'h08301500; adv();
    look(); chk(alarm_set, "R4 daily match despite date", alarm_set, 1);
    adv(2);
    look(); chk(!alarm_set, "R8 persisting match no retrigger", alarm_set, 0);
    cnt_time = 32'h08301501; adv(2);
    look(); chk(!alarm_set, "R4 one bit off no match", alarm_set, 0);

    // R5: dated alarm
    acr = 8'h30; cnt_time = 32'h08301500; adv(2);
    look(); chk(!alarm_set, "R5 date mismatch blocks", alarm_set, 0);
    cnt_time = 32'h08301501; adv();
    cnt_date = 8'hE1; cnt_wdmon = 8'hAC; cnt_time = 32'h08301500; adv();
    look(); chk(alarm_set, "R5 year/weekday ignored", alarm_set, 1);
    cnt_time = 32'h08301501; adv();

    // R6: weekday mask
    acr = 8'h20; cnt_wdmon = 8'h61; alm_wdmon = 8'h74; cnt_time = 32'h08301500; adv(2);
    look(); chk(!alarm_set, "R6 masked weekday", alarm_set, 0);
    alm_wdmon = 8'h08; adv();
    look(); chk(alarm_set, "R6 enabled weekday", alarm_set, 1);
    cnt_wdmon = 8'hE0; alm_wdmon = 8'hFF; cnt_time = 32'h08301501; adv(); cnt_time = 32'h08301500; adv(2);
    look(); chk(!alarm_set, "R6 weekday code 7", alarm_set, 0);

    // R8: mode none
    acr = 8'h00; cnt_time = 32'h08301501; adv(); cnt_time = 32'h08301500; adv(2);
    look(); chk(!alarm_set, "R8 mode none", alarm_set, 0);

    // R7: timer alarm
    acr = 8'h41; alm_timer = 8'h05; tmr_load = 1; tmr_load_val = 8'h04; adv(); tmr_load = 0;
    tick = 5'b00001; adv(); tick = 0;
    look(); chk(timer_val == 8'h05 && !alarm_set, "R7 equal, pulse pending", alarm_set, 0);
    adv();
    look(); chk(alarm_set, "R7 timer alarm", alarm_set, 1);

    // R9: interrupt enables
    acr = 8'h80; alarm_flag = 1; adv();
    look(); chk(!int_n, "R9 alarm flag enabled", int_n, 0);
    acr = 8'h00; adv();
    look(); chk(int_n, "R9 alarm flag disabled", int_n, 1);
    alarm_flag = 0; timer_flag = 1; acr = 8'h08; adv();
    look(); chk(!int_n, "R9 timer flag enabled", int_n, 0);
    timer_flag = 0; adv();
    look(); chk(int_n, "R9 flag cleared", int_n, 1);

    // R10: calibration square wave
    alarm_en = 0; clk_mode = 1; cnt_time = 32'h00000049; adv();
    look(); chk(!int_n, "R10 first half low", int_n, 0);
    cnt_time = 32'h00000050; adv();
    look(); chk(int_n, "R10 second half high", int_n, 1);
    cnt_time = 32'h00000000; adv();
    look(); chk(!int_n, "R10 wrap low", int_n, 0);
    clk_mode = 0; adv();
    look(); chk(int_n, "R10 event mode high", int_n, 1);

    adv(3);
    cmp_on = 0;
    summary();
    $finish;
  end

endmodule